// File: doc/BRIEF.md
# Sector Erase Command Acceptance Controller

This block sits on the device side of a NOR-style flash array and handles the last stage of a multi-sector erase command. A separate unlock decoder recognises the five opening bus cycles and reports them as a one-cycle `arm` pulse. The next bus write must carry the erase-confirm code 0x30. Its sector address goes into a sector-select buffer, and a timed acceptance window opens.

While the window is open the host may write further 0x30 cycles, each with a sector address. They can arrive in any order and in any number. Every accepted cycle restarts the window. When a full window passes with no write, the erase phase starts: `win_expired` rises, and the unprotected selected sectors are erased one at a time, lowest index first, each for a fixed number of cycles. The block then returns to array read mode.

If every selected sector is protected, the block only waits a fixed delay and then returns to read mode. A foreign command written during the window abandons the whole request. Once erase has begun, the only command it accepts is erase suspend (0xB0). A hardware reset input ends any activity at once.

Top module: `sector_erase_ctrl`

## Requirements
- R1: In read mode, an `arm` pulse followed by a bus write with data 0x30 opens the window: `busy` rises, `win_expired` stays 0, and `sel_vec` holds only the bit whose index equals `bus_addr`.
- R2: While the window is open, each write with data 0x30 sets the bit of its sector in `sel_vec` and keeps the earlier bits. Sectors may come in any order.
- R3: The window counts WIN_CYC cycles with no write, restarting on every accepted 0x30 write. Erase begins only after that count.
- R4: `win_expired` is 0 while the window is open. It is 1 from the cycle the erase phase starts until the block is back in read mode.
- R5: A write during the window whose data is neither 0x30 nor 0xB0 clears `sel_vec` and returns the block to read mode (`busy` = 0) on the next cycle.
- R6: Once the erase phase has started, writes other than 0xB0 change neither `sel_vec` nor the erase progress.
- R7: A 0xB0 write during the window or during erasing sets `suspended`, stops erasing (`erasing` = 0), and holds until a hardware reset.
- R8: If every selected sector is protected (`prot_mask` bit = 1), nothing is erased. `busy` stays high for PROT_WAIT_CYC cycles after expiry and then falls.
- R9: Only selected sectors with a clear `prot_mask` bit are erased. They are erased in ascending index order, each shown on `erase_sect` with `erasing` = 1 for ERASE_CYC cycles.
- R10: A `hw_reset` high at a clock edge returns the block to read mode with `busy`, `win_expired`, `suspended`, `erasing` and `sel_vec` all clear.
- R11: After the last sector is erased, the block returns to read mode by itself, with `sel_vec` cleared and `win_expired` = 0.
- R12: In read mode, a bus write that is not preceded by `arm` is ignored and opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_reset | input | 1 | Hardware reset request, synchronous, aborts any operation |
| arm | input | 1 | One-cycle pulse: unlock cycles decoded, confirm cycle expected |
| bus_wr | input | 1 | Bus write cycle complete (strobe end) |
| bus_addr | input | SECT_W | Sector-address field of the bus address |
| bus_data | input | 8 | Bus write data |
| prot_mask | input | NUM_SECT | Per-sector protection, 1 = protected |
| busy | output | 1 | High from window opening until back in read mode |
| win_expired | output | 1 | Window-expired status bit |
| suspended | output | 1 | Erase suspend accepted |
| erasing | output | 1 | A sector is being erased |
| erase_sect | output | SECT_W | Index of the sector currently being erased |
| sel_vec | output | NUM_SECT | Sector-select buffer contents |

## Verification
The bound checker watches, on every cycle, the invariants that hold at all times. A hardware reset always clears the block on the next cycle. `win_expired` and `erasing` never appear outside a busy operation. The sector being erased is always selected and unprotected. The select buffer is frozen once erase starts. A suspend latches and stays. The exact window length and its restart on each added sector, the ascending erase order, the protected-only delay and the abort on a foreign command depend on the sequence of writes. Only the bench scenarios, compared cycle by cycle against a behavioural model, can show them.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [DATA_W-1:0] CMD_SECT_ERASE = 8'h30;
  localparam logic [DATA_W-1:0] CMD_SUSPEND    = 8'hB0;

  typedef enum logic [2:0] {
    ST_READ   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_WINDOW = 3'd2,
    ST_ERASE  = 3'd3,
    ST_PWAIT  = 3'd4,
    ST_SUSP   = 3'd5
  } se_state_t;
endpackage

// File: rtl/se_sector_decode.sv
module se_sector_decode #(
  parameter int unsigned NUM_SECT = 8,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic [SECT_W-1:0]   idx,
  output logic [NUM_SECT-1:0] onehot
);
  for (genvar g = 0; g < NUM_SECT; g++) begin : g_dec
    assign onehot[g] = (idx == SECT_W'(g));
  end
endmodule

// File: rtl/se_cycle_timer.sv
module se_cycle_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = run && !clr && (cnt_q == CNT_W'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/se_erase_seq.sv
module se_erase_seq #(
  parameter int unsigned NUM_SECT  = 8,
  parameter int unsigned ERASE_CYC = 16,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int unsigned CNT_W  = $clog2(ERASE_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                load,
  input  logic [NUM_SECT-1:0] load_mask,
  input  logic                run,
  output logic [SECT_W-1:0]   cur_idx,
  output logic                all_done
);
  logic [NUM_SECT-1:0] rem_q, rem_d, cur_oh;
  logic [CNT_W-1:0]    ecnt_q, ecnt_d;
  logic                step_done;

  // lowest pending sector wins
  always_comb begin
    cur_idx = '0;
    for (int i = NUM_SECT - 1; i >= 0; i--) begin
      if (rem_q[i]) cur_idx = SECT_W'(i);
    end
  end

  se_sector_decode #(.NUM_SECT(NUM_SECT)) i_cur_dec (
    .idx    (cur_idx),
    .onehot (cur_oh)
  );

  assign step_done = run && (|rem_q) && (ecnt_q == CNT_W'(ERASE_CYC - 1));
  assign all_done  = step_done && ((rem_q & ~cur_oh) == '0);

  always_comb begin
    rem_d  = rem_q;
    ecnt_d = ecnt_q;
    if (flush) begin
      rem_d  = '0;
      ecnt_d = '0;
    end else if (load) begin
      rem_d  = load_mask;
      ecnt_d = '0;
    end else if (step_done) begin
      rem_d  = rem_q & ~cur_oh;
      ecnt_d = '0;
    end else if (run) begin
      ecnt_d = ecnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      ecnt_q <= '0;
    end else begin
      rem_q  <= rem_d;
      ecnt_q <= ecnt_d;
    end
  end
endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl #(
  parameter int unsigned NUM_SECT      = 8,
  parameter int unsigned WIN_CYC       = 2500,
  parameter int unsigned PROT_WAIT_CYC = 5000,
  parameter int unsigned ERASE_CYC     = 1000,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_reset,
  input  logic                arm,
  input  logic                bus_wr,
  input  logic [SECT_W-1:0]   bus_addr,
  input  logic [7:0]          bus_data,
  input  logic [NUM_SECT-1:0] prot_mask,
  output logic                busy,
  output logic                win_expired,
  output logic                suspended,
  output logic                erasing,
  output logic [SECT_W-1:0]   erase_sect,
  output logic [NUM_SECT-1:0] sel_vec
);
  import sec_erase_pkg::*;

  se_state_t           st_q, st_d;
  logic [NUM_SECT-1:0] sel_q, sel_d, addr_oh, erasable;
  logic                exp_q, exp_d, susp_q, susp_d;
  logic                is_se, is_susp;
  logic                win_clr, win_run, win_done;
  logic                pw_clr, pw_run, pw_done;
  logic                seq_load, seq_run, seq_done;

  assign is_se    = bus_wr && (bus_data == CMD_SECT_ERASE);
  assign is_susp  = bus_wr && (bus_data == CMD_SUSPEND);
  assign erasable = sel_q & ~prot_mask;

  se_sector_decode #(.NUM_SECT(NUM_SECT)) i_addr_dec (
    .idx    (bus_addr),
    .onehot (addr_oh)
  );

  se_cycle_timer #(.LIMIT(WIN_CYC)) i_win_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win_clr),
    .run   (win_run),
    .done  (win_done)
  );

  se_cycle_timer #(.LIMIT(PROT_WAIT_CYC)) i_pw_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pw_clr),
    .run   (pw_run),
    .done  (pw_done)
  );

  se_erase_seq #(.NUM_SECT(NUM_SECT), .ERASE_CYC(ERASE_CYC)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (hw_reset),
    .load      (seq_load),
    .load_mask (erasable),
    .run       (seq_run),
    .cur_idx   (erase_sect),
    .all_done  (seq_done)
  );

  assign win_run = (st_q == ST_WINDOW) && !bus_wr && !hw_reset;
  assign pw_run  = (st_q == ST_PWAIT) && !hw_reset;
  assign seq_run = (st_q == ST_ERASE) && !is_susp && !hw_reset;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    exp_d    = exp_q;
    susp_d   = susp_q;
    win_clr  = 1'b0;
    pw_clr   = 1'b0;
    seq_load = 1'b0;
    if (hw_reset) begin
      st_d   = ST_READ;
      sel_d  = '0;
      exp_d  = 1'b0;
      susp_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_READ: begin
          if (arm) st_d = ST_ARMED;
        end
        ST_ARMED: begin
          if (is_se) begin
            st_d    = ST_WINDOW;
            sel_d   = addr_oh;
            win_clr = 1'b1;
          end else if (bus_wr) begin
            st_d = ST_READ;
          end
        end
        ST_WINDOW: begin
          if (is_se) begin
            sel_d   = sel_q | addr_oh;
            win_clr = 1'b1;
          end else if (is_susp) begin
            st_d   = ST_SUSP;
            susp_d = 1'b1;
          end else if (bus_wr) begin
            st_d  = ST_READ;
            sel_d = '0;
          end else if (win_done) begin
            exp_d = 1'b1;
            if (erasable == '0) begin
              st_d   = ST_PWAIT;
              pw_clr = 1'b1;
            end else begin
              st_d     = ST_ERASE;
              seq_load = 1'b1;
            end
          end
        end
        ST_ERASE: begin
          if (is_susp) begin
            st_d   = ST_SUSP;
            susp_d = 1'b1;
          end else if (seq_done) begin
            st_d  = ST_READ;
            sel_d = '0;
            exp_d = 1'b0;
          end
        end
        ST_PWAIT: begin
          if (pw_done) begin
            st_d  = ST_READ;
            sel_d = '0;
            exp_d = 1'b0;
          end
        end
        ST_SUSP: begin
          st_d = ST_SUSP;
        end
        default: st_d = ST_READ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_READ;
      sel_q  <= '0;
      exp_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      exp_q  <= exp_d;
      susp_q <= susp_d;
    end
  end

  assign busy        = (st_q == ST_WINDOW) || (st_q == ST_ERASE) ||
                       (st_q == ST_PWAIT)  || (st_q == ST_SUSP);
  assign win_expired = exp_q;
  assign suspended   = susp_q;
  assign erasing     = (st_q == ST_ERASE);
  assign sel_vec     = sel_q;
endmodule

// File: rtl/se_erase_checker.sv
module se_erase_checker #(
  parameter int unsigned NUM_SECT = 8,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hw_reset,
  input logic [NUM_SECT-1:0] prot_mask,
  input logic                busy,
  input logic                win_expired,
  input logic                suspended,
  input logic                erasing,
  input logic [SECT_W-1:0]   erase_sect,
  input logic [NUM_SECT-1:0] sel_vec
);
  a_r10_hw_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |=> (!busy && !win_expired && !suspended && !erasing && sel_vec == '0));

  a_r4_expired_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    win_expired |-> busy);

  a_r4_erase_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> win_expired);

  a_r9_erase_selected_unprot: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> (sel_vec[erase_sect] && !prot_mask[erase_sect]));

  a_r6_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (win_expired && !hw_reset) |=> ($stable(sel_vec) || sel_vec == '0));

  a_r7_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !hw_reset) |=> (suspended && busy && !erasing));
endmodule

bind sector_erase_ctrl se_erase_checker #(.NUM_SECT(NUM_SECT)) i_se_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hw_reset    (hw_reset),
  .prot_mask   (prot_mask),
  .busy        (busy),
  .win_expired (win_expired),
  .suspended   (suspended),
  .erasing     (erasing),
  .erase_sect  (erase_sect),
  .sel_vec     (sel_vec)
);

// File: tb/test_sector_erase_ctrl.sv
`timescale 1ns/1ps
module test_sector_erase_ctrl;
  localparam int NS  = 8;
  localparam int SW  = 3;
  localparam int WIN = 10;
  localparam int PW  = 25;
  localparam int EC  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hw_reset = 1'b0, arm = 1'b0, bus_wr = 1'b0;
  logic [SW-1:0] bus_addr = '0;
  logic [7:0]    bus_data = '0;
  logic [NS-1:0] prot_mask = '0;
  logic          busy, win_expired, suspended, erasing;
  logic [SW-1:0] erase_sect;
  logic [NS-1:0] sel_vec;

  always #10 clk = ~clk;

  sector_erase_ctrl #(.NUM_SECT(NS), .WIN_CYC(WIN), .PROT_WAIT_CYC(PW), .ERASE_CYC(EC))
    i_sector_erase_ctrl (.*);

  int n_chk = 0, n_fail = 0;
  string cur_req = "R10";
  bit finished = 0;

  // behavioural reference: 0 read, 1 armed, 2 window, 3 erase, 4 prot wait, 5 suspended
  int      m_mode, m_quiet, m_tick, m_pw;
  int      m_q[$];
  bit [NS-1:0] m_sel;
  bit      m_exp, m_susp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_sel = '0; m_exp = 0; m_susp = 0; m_q.delete(); m_tick = 0;
      m_quiet = 0; m_pw = 0;
    end else if (hw_reset) begin
      m_mode = 0; m_sel = '0; m_exp = 0; m_susp = 0; m_q.delete(); m_tick = 0;
    end else begin
      case (m_mode)
        0: if (arm) m_mode = 1;
        1: if (bus_wr) begin
             if (bus_data == 8'h30) begin m_mode = 2; m_sel = '0; m_sel[bus_addr] = 1'b1; m_quiet = 0; end
             else m_mode = 0;
           end
        2: if (bus_wr) begin
             if (bus_data == 8'h30) begin m_sel[bus_addr] = 1'b1; m_quiet = 0; end
             else if (bus_data == 8'hB0) begin m_mode = 5; m_susp = 1; end
             else begin m_mode = 0; m_sel = '0; end
           end else begin
             m_quiet++;
             if (m_quiet == WIN) begin
               m_exp = 1;
               for (int s = 0; s < NS; s++) if (m_sel[s] && !prot_mask[s]) m_q.push_back(s);
               if (m_q.size() == 0) begin m_mode = 4; m_pw = 0; end
               else begin m_mode = 3; m_tick = 0; end
             end
           end
        3: if (bus_wr && bus_data == 8'hB0) begin m_mode = 5; m_susp = 1; end
           else begin
             m_tick++;
             if (m_tick == EC) begin
               void'(m_q.pop_front()); m_tick = 0;
               if (m_q.size() == 0) begin m_mode = 0; m_sel = '0; m_exp = 0; end
             end
           end
        4: begin
             m_pw++;
             if (m_pw == PW) begin m_mode = 0; m_sel = '0; m_exp = 0; end
           end
        default: ;
      endcase
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "busy",        busy,        (m_mode >= 2));
    chk(cur_req, "win_expired", win_expired, m_exp);
    chk(cur_req, "suspended",   suspended,   m_susp);
    chk(cur_req, "erasing",     erasing,     (m_mode == 3));
    chk(cur_req, "erase_sect",  erase_sect,  (m_q.size() > 0) ? m_q[0] : 0);
    chk(cur_req, "sel_vec",     sel_vec,     m_sel);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic wr(int sect, logic [7:0] d);
    @(negedge clk) begin bus_wr = 1'b1; bus_addr = SW'(sect); bus_data = d; end
    @(negedge clk) bus_wr = 1'b0;
  endtask

  task automatic pulse_hw();
    @(negedge clk) hw_reset = 1'b1;
    @(negedge clk) hw_reset = 1'b0;
  endtask

  task automatic wait_read(int lim);
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R10";
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset sel", sel_vec, 0);

    // R12: write without arm is ignored
    cur_req = "R12";
    wr(2, 8'h30); idle(2);
    chk("R12", "no window", busy, 0);

    // R1 + R11: single sector
    cur_req = "R1";
    do_arm(); wr(3, 8'h30);
    chk("R1", "sel one-hot", sel_vec, 8'h08);
    chk("R1", "expired low", win_expired, 0);
    cur_req = "R11";
    wait_read(200);
    chk("R11", "back to read", busy, 0);
    chk("R11", "sel cleared", sel_vec, 0);

    // R2 + R3: out-of-order sectors, window restarted each time
    cur_req = "R3";
    do_arm(); wr(5, 8'h30); idle(WIN - 3); wr(1, 8'h30); idle(WIN - 3); wr(6, 8'h30);
    chk("R2", "accumulate", sel_vec, 8'h62);
    idle(WIN - 3);
    chk("R3", "still window", win_expired, 0);
    idle(3);
    chk("R3", "expired", win_expired, 1);
    cur_req = "R9";
    wait_read(400);

    // R9: protected ones skipped
    prot_mask = 8'h22;
    do_arm(); wr(1, 8'h30); wr(2, 8'h30); wr(5, 8'h30);
    idle(WIN + 1);
    chk("R9", "erases sector 2", erase_sect, 2);
    wait_read(400);
    chk("R9", "done", busy, 0);

    // R8: all protected
    cur_req = "R8";
    do_arm(); wr(1, 8'h30); wr(5, 8'h30);
    idle(WIN + 2);
    chk("R8", "no erasing", erasing, 0);
    chk("R8", "busy waiting", busy, 1);
    wait_read(400);
    prot_mask = '0;

    // R5: foreign command in window
    cur_req = "R5";
    do_arm(); wr(4, 8'h30); wr(0, 8'hF0);
    chk("R5", "aborted", busy, 0);
    chk("R5", "buffer cleared", sel_vec, 0);

    // R6: commands ignored during erase
    cur_req = "R6";
    do_arm(); wr(0, 8'h30); wr(7, 8'h30); idle(WIN + 1);
    wr(3, 8'h30); wr(2, 8'hF0); wr(4, 8'h90);
    chk("R6", "buffer unchanged", sel_vec, 8'h81);
    chk("R6", "still erasing", erasing, 1);
    wait_read(400);

    // R7: suspend during erase, then R10 hardware reset
    cur_req = "R7";
    do_arm(); wr(2, 8'h30); idle(WIN + 2); wr(0, 8'hB0); idle(EC + 3);
    chk("R7", "suspended", suspended, 1);
    chk("R7", "not erasing", erasing, 0);
    cur_req = "R10";
    pulse_hw();
    chk("R10", "hw reset clears", suspended, 0);

    // R7: suspend during window
    cur_req = "R7";
    do_arm(); wr(6, 8'h30); wr(1, 8'hB0); idle(WIN + 3);
    chk("R7", "suspended in window", suspended, 1);
    chk("R4", "expired stays low", win_expired, 0);
    pulse_hw();

    // R10: hardware reset mid-erase
    cur_req = "R10";
    do_arm(); wr(3, 8'h30); wr(4, 8'h30); idle(WIN + 3);
    pulse_hw();
    chk("R10", "erase ended", erasing, 0);
    chk("R10", "busy low", busy, 0);
    idle(5);
    finish_run();
  end
endmodule